// File: doc/BRIEF.md
# Two-Stage Chained Arithmetic Core with Operand Routing

This block is the arithmetic heart of an operator engine. It takes four conditioned input lanes per sample and feeds two two-input integer units, operation I and operation II, through an operand routing matrix. Each of the four operand ports is given a small source ID. The ID picks one of the input lanes, or, on the ports of operation II, the result of operation I. This lets one pass through the core evaluate chained forms such as `a*b + c` or `(a-b)^2`. Each unit can be set to add, subtract or multiply.

The two units have different pipeline depths. Lane operands bound for operation II are delayed by the depth of operation I, so they meet the chained result of the same sample. In single-operation mode, operation I's result is delayed by the depth of operation II. The total latency is therefore the same in every mode. The whole pipeline moves on one advance condition taken from a valid/ready handshake at the output. A stall freezes every stage together, so no sample is lost or repeated.

The configuration inputs are meant to stay static while samples are in flight. A bad configuration is flagged on a registered error output. While that flag is high, no result is released.

Top module: `dop_core`

## Requirements
- R1: Each operand port has a 3-bit source ID. ID 1, 2, 3 and 4 select input lanes 0, 1, 2 and 3. Lane k sits at `lanes_in[k*W +: W]`. ID 0 selects operation I's result and is legal only on the two operation II ports.
- R2: Operator code 0 adds (a+b). Code 1 subtracts (a-b, port a minus port b). Code 2 multiplies and keeps the low W bits. All results wrap modulo 2^W.
- R3: An operation II port bound to ID 0 receives operation I's result for the same sample. An operation II port bound to a lane receives that same sample's lane value.
- R4: With `out_ready` held high, the result of a sample accepted at a clock edge appears with `out_valid` high exactly LAT1+LAT2+1 edges after that edge, counting the accepting edge.
- R5: When `single_mode` is 1, the output is operation I's result with the same latency as in R4. The operation II source IDs and operator code are ignored and raise no error.
- R6: A source ID of 5, 6 or 7 on an active port, ID 0 on an operation I port, or operator code 3 on an active unit sets `cfg_err` one edge later. While `cfg_err` is high, `out_valid` stays low.
- R7: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. Every accepted sample leaves exactly once, in acceptance order.
- R8: After a synchronous reset, `out_valid` and `cfg_err` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Core accepts a sample this cycle |
| lanes_in | input | 4*W | Four conditioned input lanes |
| op1_a_src | input | 3 | Source ID of operation I port a |
| op1_b_src | input | 3 | Source ID of operation I port b |
| op2_a_src | input | 3 | Source ID of operation II port a |
| op2_b_src | input | 3 | Source ID of operation II port b |
| op1_sel | input | 2 | Operator code of operation I |
| op2_sel | input | 2 | Operator code of operation II |
| single_mode | input | 1 | 1: output operation I only |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W | Result |
| cfg_err | output | 1 | Registered configuration error flag |

## Verification
Every sample's result is due LAT1+LAT2+1 advancing edges after the edge that accepted it. `cfg_err` is due one edge after the configuration it judges. The bench models this with a behavioural slot array that shifts only on edges where the model's own advance condition holds. It samples all outputs on the falling edge after the model has taken the same rising edge, and compares every cycle. A separate single-sample run counts the edges from acceptance to `out_valid` explicitly. A randomly stalled stream compares the number of results received against the number of samples sent.

// File: rtl/dop_pkg.sv
package dop_pkg;
  localparam int NLANES = 4;
  localparam int IDW    = 3;
  localparam logic [IDW-1:0] ID_CHAIN = '0;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_BAD = 2'd3
  } op_e;

  function automatic logic id_out_of_range(input logic [IDW-1:0] id);
    return id > IDW'(NLANES);
  endfunction
endpackage

// File: rtl/dop_delay.sv
module dop_delay #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else if (en) begin
      st[0] <= d;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[DEPTH-1];

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
endmodule

// File: rtl/dop_route.sv
module dop_route
  import dop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [NLANES*W-1:0] lanes_i,
  input  logic [IDW-1:0]      id_i,
  output logic [W-1:0]        val_o
);
  always_comb begin
    val_o = '0;
    for (int k = 0; k < NLANES; k++)
      if (id_i == IDW'(k + 1)) val_o = lanes_i[k*W +: W];
  end
endmodule

// File: rtl/dop_unit.sv
module dop_unit
  import dop_pkg::*;
#(
  parameter int W   = 16,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] r_o
);
  logic [W-1:0] f;

  always_comb begin
    case (op_e'(op_i))
      OP_ADD:  f = a_i + b_i;
      OP_SUB:  f = a_i - b_i;
      OP_MUL:  f = a_i * b_i;
      default: f = '0;
    endcase
  end

  dop_delay #(.W(W), .DEPTH(LAT)) u_pipe (
    .clk(clk), .rst(rst), .en(en), .d(f), .q(r_o)
  );
endmodule

// File: rtl/dop_core.sv
module dop_core
  import dop_pkg::*;
#(
  parameter int W    = 16,
  parameter int LAT1 = 3,
  parameter int LAT2 = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [NLANES*W-1:0] lanes_in,
  input  logic [IDW-1:0]      op1_a_src,
  input  logic [IDW-1:0]      op1_b_src,
  input  logic [IDW-1:0]      op2_a_src,
  input  logic [IDW-1:0]      op2_b_src,
  input  logic [1:0]          op1_sel,
  input  logic [1:0]          op2_sel,
  input  logic                single_mode,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [W-1:0]        out_data,
  output logic                cfg_err
);
  localparam int TOT   = LAT1 + LAT2;
  localparam int NPORT = 4;

  logic [IDW-1:0] src [NPORT];
  logic [W-1:0]   port_val [NPORT];
  logic           err_d, err1, err2, adv, fire, tail_v;
  logic [W-1:0]   r1, r1d, r2, l2a, l2b, op2a, op2b;
  logic           ov_q, err_q;
  logic [W-1:0]   od_q;

  assign src[0] = op1_a_src;
  assign src[1] = op1_b_src;
  assign src[2] = op2_a_src;
  assign src[3] = op2_b_src;

  // configuration check: operation I may never take the chained ID
  assign err1  = id_out_of_range(op1_a_src) | id_out_of_range(op1_b_src) |
                 (op1_a_src == ID_CHAIN) | (op1_b_src == ID_CHAIN) |
                 (op_e'(op1_sel) == OP_BAD);
  assign err2  = id_out_of_range(op2_a_src) | id_out_of_range(op2_b_src) |
                 (op_e'(op2_sel) == OP_BAD);
  assign err_d = err1 | (!single_mode & err2);

  assign adv      = !ov_q | out_ready;
  assign in_ready = adv;
  assign fire     = in_valid & adv;

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_route
      dop_route #(.W(W)) u_rt (
        .lanes_i(lanes_in), .id_i(src[p]), .val_o(port_val[p])
      );
    end
  endgenerate

  dop_unit #(.W(W), .LAT(LAT1)) u_op1 (
    .clk(clk), .rst(rst), .en(adv), .op_i(op1_sel),
    .a_i(port_val[0]), .b_i(port_val[1]), .r_o(r1)
  );

  // lane operands of operation II wait out operation I's depth
  dop_delay #(.W(2*W), .DEPTH(LAT1)) u_align2 (
    .clk(clk), .rst(rst), .en(adv),
    .d({port_val[2], port_val[3]}), .q({l2a, l2b})
  );

  assign op2a = (op2_a_src == ID_CHAIN) ? r1 : l2a;
  assign op2b = (op2_b_src == ID_CHAIN) ? r1 : l2b;

  dop_unit #(.W(W), .LAT(LAT2)) u_op2 (
    .clk(clk), .rst(rst), .en(adv), .op_i(op2_sel),
    .a_i(op2a), .b_i(op2b), .r_o(r2)
  );

  // single-operation path padded to the same total depth
  dop_delay #(.W(W), .DEPTH(LAT2)) u_pad1 (
    .clk(clk), .rst(rst), .en(adv), .d(r1), .q(r1d)
  );

  dop_delay #(.W(1), .DEPTH(TOT)) u_vld (
    .clk(clk), .rst(rst), .en(adv), .d(fire), .q(tail_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q  <= 1'b0;
      od_q  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
      if (err_d) begin
        ov_q <= 1'b0;
      end else if (adv) begin
        ov_q <= tail_v;
        od_q <= single_mode ? r1d : r2;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign cfg_err   = err_q;

  // R6
  err_blocks_valid_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !out_valid);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> (out_valid && $stable(out_data)) || cfg_err);

  // R1
  op1_chain_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (op1_a_src == ID_CHAIN || op1_b_src == ID_CHAIN) |=> cfg_err);

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !out_valid && !cfg_err);
endmodule

// File: tb/sim_dop_core.sv
module sim_dop_core;
  localparam int W    = 16;
  localparam int LAT1 = 3;
  localparam int LAT2 = 2;
  localparam int TOT  = LAT1 + LAT2;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0, out_ready = 1, single_mode = 0;
  logic [4*W-1:0] lanes_in = '0;
  logic [2:0] op1_a_src = 3'd1, op1_b_src = 3'd2, op2_a_src = 3'd3, op2_b_src = 3'd4;
  logic [1:0] op1_sel = 2'd0, op2_sel = 2'd0;
  logic in_ready, out_valid, cfg_err;
  logic [W-1:0] out_data;

  always #10 clk = ~clk;

  dop_core #(.W(W), .LAT1(LAT1), .LAT2(LAT2)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .lanes_in(lanes_in), .op1_a_src(op1_a_src), .op1_b_src(op1_b_src),
    .op2_a_src(op2_a_src), .op2_b_src(op2_b_src), .op1_sel(op1_sel),
    .op2_sel(op2_sel), .single_mode(single_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .cfg_err(cfg_err)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, sent = 0, recv = 0;
  bit done = 0;
  string req = "R8";
  bit mv [0:TOT];
  logic [W-1:0] md [0:TOT];
  bit errq = 0;

  task automatic chk(input string r, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", r, act, exp, cyc);
    end
  endtask

  function automatic logic [W-1:0] fop(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a * b;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] lane(input int k);
    return lanes_in[k*W +: W];
  endfunction

  function automatic bit cfg_bad();
    bit e1, e2;
    e1 = (op1_a_src == 0) || (op1_a_src > 4) || (op1_b_src == 0) || (op1_b_src > 4) || (op1_sel == 3);
    e2 = (op2_a_src > 4) || (op2_b_src > 4) || (op2_sel == 3);
    return e1 || (!single_mode && e2);
  endfunction

  function automatic logic [W-1:0] expect_result();
    logic [W-1:0] r1, a2, b2;
    r1 = fop(op1_sel, lane(int'(op1_a_src) - 1), lane(int'(op1_b_src) - 1));
    if (single_mode) return r1;
    a2 = (op2_a_src == 0) ? r1 : lane(int'(op2_a_src) - 1);
    b2 = (op2_b_src == 0) ? r1 : lane(int'(op2_b_src) - 1);
    return fop(op2_sel, a2, b2);
  endfunction

  // one clock: inputs already driven; check ready, take edge, update model, compare
  task automatic cycle();
    bit adv, en;
    #1;
    adv = !mv[TOT] || out_ready;
    chk("R7", {15'd0, in_ready}, {15'd0, adv});
    if (out_valid && out_ready) recv++;
    @(posedge clk);
    en = cfg_bad();
    if (en) mv[TOT] = 0;
    else if (adv) begin mv[TOT] = mv[TOT-1]; md[TOT] = md[TOT-1]; end
    if (adv) begin
      for (int i = TOT - 1; i > 0; i--) begin mv[i] = mv[i-1]; md[i] = md[i-1]; end
      mv[0] = in_valid;
      md[0] = expect_result();
      if (in_valid) sent++;
    end
    errq = en;
    @(negedge clk);
    cyc++;
    chk(req, {15'd0, out_valid}, {15'd0, mv[TOT]});
    chk(req, {15'd0, cfg_err}, {15'd0, errq});
    if (mv[TOT] && out_valid) chk(req, out_data, md[TOT]);
  endtask

  task automatic push_random(input int n, input bit rand_ready);
    for (int i = 0; i < n; i++) begin
      lanes_in = {16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom)};
      in_valid = 1;
      out_ready = rand_ready ? 1'($urandom) : 1'b1;
      cycle();
    end
    in_valid = 0;
  endtask

  task automatic drain();
    out_ready = 1;
    in_valid = 0;
    for (int i = 0; i < TOT + 3; i++) cycle();
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int lat;
    for (int i = 0; i <= TOT; i++) begin mv[i] = 0; md[i] = '0; end
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R8: reset state
    chk("R8", {15'd0, out_valid}, 16'd0);
    chk("R8", {15'd0, cfg_err}, 16'd0);
    chk("R8", {15'd0, in_ready}, 16'd1);

    // R1 plain lane routing, op II multiplies lanes 2 and 3
    req = "R1"; op1_sel = 0; op2_sel = 2;
    push_random(8, 0); drain();

    // R3 chained a*b + c
    req = "R3"; op1_sel = 2; op2_sel = 0; op2_a_src = 0; op2_b_src = 3;
    push_random(8, 0); drain();

    // R2 subtract with swapped ports, then square through both chained ports
    req = "R2"; op1_sel = 1; op1_a_src = 2; op1_b_src = 1; op2_a_src = 0; op2_b_src = 0; op2_sel = 2;
    push_random(8, 0); drain();

    // R4 explicit latency count
    req = "R4"; op1_a_src = 1; op1_b_src = 2; op2_a_src = 3; op2_b_src = 4; op1_sel = 0; op2_sel = 0;
    lanes_in = {16'd4, 16'd3, 16'd2, 16'd1}; in_valid = 1; out_ready = 1;
    cycle(); in_valid = 0; lat = 1;
    while (!out_valid && lat < 20) begin cycle(); lat++; end
    chk("R4", 16'(lat), 16'(TOT + 1));
    chk("R4", out_data, 16'd7);
    drain();

    // R5 single mode ignores bad op II settings
    req = "R5"; single_mode = 1; op2_a_src = 7; op2_b_src = 6; op2_sel = 3; op1_sel = 2;
    push_random(8, 0); drain();
    chk("R5", {15'd0, cfg_err}, 16'd0);
    single_mode = 0; op2_a_src = 0; op2_b_src = 4; op2_sel = 1; op1_sel = 0;

    // R7 random backpressure, loss-free and ordered
    req = "R7"; sent = 0; recv = 0;
    push_random(40, 1); drain();
    chk("R7", 16'(recv), 16'(sent));

    // R6 error cases
    req = "R6";
    op1_a_src = 5; push_random(6, 0); drain(); chk("R6", {15'd0, cfg_err}, 16'd1);
    op1_a_src = 1; op1_b_src = 0; push_random(6, 0); drain(); chk("R6", {15'd0, cfg_err}, 16'd1);
    op1_b_src = 2; op2_sel = 3; push_random(6, 0); drain(); chk("R6", {15'd0, cfg_err}, 16'd1);
    op2_sel = 0; drain(); chk("R6", {15'd0, cfg_err}, 16'd0);
    req = "R1"; push_random(6, 0); drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule